// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block sits between a narrow register bus and a hardware core. Bus accesses are single-cycle: an address, a write enable and an 8-bit write-data word go in, and a registered 8-bit read-data word comes out. The bank holds two kinds of register.

Pass-through registers do not store anything for the core. A bus write to one of them is handed to the core as a data word plus a single-cycle strobe. A bus read of one of them returns a word that the core drives continuously. Field registers are stored inside the bank. Each is built from fields, and each field has its own access policy on the bus side and its own policy on the core side. All fields are packed into one vector, which is cut into bus-word slices. The slice holding the most significant bits sits at the lowest address. The core reads field values through a packed output and can overwrite individual fields through a packed input with one enable per field.

With the default parameters there are two pass-through registers and four fields, 16 bits in total, spread over two words.

Top module: `csr_bank`

## Requirements
- R1: While reset is asserted, every stored field is zero, both pass-through strobes are low and the packed core field output is zero.
- R2: A bus write to pass-through address 0 or 1 raises that register's strobe for exactly one cycle, in the cycle after the write edge. The written word is presented on its data output during that cycle. Any other access leaves both strobes low.
- R3: A bus read of pass-through address i returns the core-supplied word for register i (bits 8i+7..8i of `raw_rdata_i`) as it stood at the read edge.
- R4: The field vector is packed as follows: field 0 in bits 3:0 (bus read-write, core read-only), field 1 in bits 9:4 (bus read-only, core write-only), field 2 in bits 12:10 (read-write on both sides), field 3 in bits 15:13 (bus write-only, core read-only). Address 2 holds vector bits 15:8 and address 3 holds bits 7:0.
- R5: A bus write stores its data bits into every bus-writable field bit that the addressed word covers. For core-readable fields, the new value appears on `fld_rd_o` after the write edge.
- R6: A bus write leaves bus-read-only field bits unchanged.
- R7: A bus read returns zero in the bit positions of bus-write-only fields.
- R8: When `fld_we_i[f]` is high, a core-writable field f takes the matching bits of `fld_wdata_i`. The enable has no effect on a field that the core cannot write.
- R9: When a bus write and a core write hit the same field in the same cycle, the field takes the core value.
- R10: Read data is registered and appears one cycle after the address. A read of the word being written in that same cycle returns the value held before the write.
- R11: Addresses 4 and above read as zero, and writes to them change no field and raise no strobe.
- R12: `fld_rd_o` shows zero in the bit positions of fields that the core cannot read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W (4) | Register word address |
| bus_we_i | input | 1 | Bus write enable |
| bus_wdata_i | input | BUS_W (8) | Bus write data |
| bus_rdata_o | output | BUS_W (8) | Registered bus read data |
| raw_wdata_o | output | N_RAW*BUS_W (16) | Last written word per pass-through register |
| raw_wstb_o | output | N_RAW (2) | One-cycle write strobe per pass-through register |
| raw_rdata_i | input | N_RAW*BUS_W (16) | Core-supplied read word per pass-through register |
| fld_rd_o | output | PAD_W (16) | Stored field values, zero for fields the core cannot read |
| fld_we_i | input | N_FLD (4) | Core write enable per field |
| fld_wdata_i | input | PAD_W (16) | Core write data, packed like the field vector |

## Verification
A stored field bit that is wrong shows on `fld_rd_o` one cycle after the faulty update, as long as the core can read that field. Fields that the core cannot read (field 1) only show a fault on `bus_rdata_o` one cycle after a bus read of their word. Field 3 cannot be read by the bus, so it is observed only through the core output. A misplaced slice boundary or an inverted most-significant-first order moves bits between addresses 2 and 3, which is visible on the very next read. A stuck or stretched strobe shows up on the cycle after any write.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    typedef enum logic [1:0] {
        ACC_RO = 2'd0,
        ACC_WO = 2'd1,
        ACC_RW = 2'd2
    } acc_e;

    function automatic logic acc_can_rd(acc_e a);
        return (a == ACC_RO) || (a == ACC_RW);
    endfunction

    function automatic logic acc_can_wr(acc_e a);
        return (a == ACC_WO) || (a == ACC_RW);
    endfunction

endpackage

// File: rtl/csr_raw_port.sv
module csr_raw_port #(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 4,
    parameter int MY_ADDR = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic              stb_o,
    output logic [BUS_W-1:0]  data_o
);

    typedef struct packed {
        logic             stb;
        logic [BUS_W-1:0] data;
    } raw_st_t;

    raw_st_t st_d, st_q;

    always_comb begin
        logic hit;
        st_d = st_q;
        hit = bus_we_i && (int'(bus_addr_i) == MY_ADDR);
        st_d.stb = hit;
        if (hit) begin
            st_d.data = bus_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o  = st_q.stb;
    assign data_o = st_q.data;

endmodule

// File: rtl/csr_field_store.sv
module csr_field_store
    import csr_bank_pkg::*;
#(
    parameter int   W       = 4,
    parameter acc_e BUS_ACC = ACC_RW,
    parameter acc_e DEV_ACC = ACC_RW
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] bus_bwe_i,
    input  logic [W-1:0] bus_bwd_i,
    input  logic         dev_we_i,
    input  logic [W-1:0] dev_wd_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] dev_rd_o,
    output logic [W-1:0] bus_rd_o
);

    localparam logic BUS_WR = acc_can_wr(BUS_ACC);
    localparam logic BUS_RD = acc_can_rd(BUS_ACC);
    localparam logic DEV_WR = acc_can_wr(DEV_ACC);
    localparam logic DEV_RD = acc_can_rd(DEV_ACC);

    typedef struct packed {
        logic [W-1:0] val;
    } fld_st_t;

    fld_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < W; j++) begin
            if (BUS_WR && bus_bwe_i[j]) begin
                st_d.val[j] = bus_bwd_i[j];
            end
        end
        // core side is applied last so it wins a same-cycle collision
        if (DEV_WR && dev_we_i) begin
            st_d.val = dev_wd_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o    = st_q.val;
    assign dev_rd_o = DEV_RD ? st_q.val : '0;
    assign bus_rd_o = BUS_RD ? st_q.val : '0;

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux #(
    parameter int BUS_W   = 8,
    parameter int ADDR_W  = 4,
    parameter int N_RAW   = 2,
    parameter int N_WORDS = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [N_RAW*BUS_W-1:0]   raw_rdata_i,
    input  logic [N_WORDS*BUS_W-1:0] fld_view_i,
    output logic [BUS_W-1:0]         rdata_o
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        for (int i = 0; i < N_RAW; i++) begin
            if (int'(bus_addr_i) == i) begin
                st_d.rdata = raw_rdata_i[i*BUS_W +: BUS_W];
            end
        end
        // slice k counts from the most significant end
        for (int k = 0; k < N_WORDS; k++) begin
            if (int'(bus_addr_i) == N_RAW + k) begin
                st_d.rdata = fld_view_i[(N_WORDS-1-k)*BUS_W +: BUS_W];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int   BUS_W  = 8,
    parameter int   ADDR_W = 4,
    parameter int   N_RAW  = 2,
    parameter int   N_FLD  = 4,
    parameter int   FLD_W   [N_FLD] = '{4, 6, 3, 3},
    parameter acc_e BUS_ACC [N_FLD] = '{ACC_RW, ACC_RO, ACC_RW, ACC_WO},
    parameter acc_e DEV_ACC [N_FLD] = '{ACC_RO, ACC_WO, ACC_RW, ACC_RO},
    localparam int  TOTAL_W_L = 16,
    localparam int  PAD_W = ((TOTAL_W_L + BUS_W - 1) / BUS_W) * BUS_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic                   bus_we_i,
    input  logic [BUS_W-1:0]       bus_wdata_i,
    output logic [BUS_W-1:0]       bus_rdata_o,
    output logic [N_RAW*BUS_W-1:0] raw_wdata_o,
    output logic [N_RAW-1:0]       raw_wstb_o,
    input  logic [N_RAW*BUS_W-1:0] raw_rdata_i,
    output logic [PAD_W-1:0]       fld_rd_o,
    input  logic [N_FLD-1:0]       fld_we_i,
    input  logic [PAD_W-1:0]       fld_wdata_i
);

    function automatic int fld_lsb(int idx);
        int s = 0;
        for (int i = 0; i < idx; i++) begin
            s += FLD_W[i];
        end
        return s;
    endfunction

    localparam int TOTAL_W = fld_lsb(N_FLD);
    localparam int N_WORDS = PAD_W / BUS_W;
    localparam int MAP_END = N_RAW + N_WORDS;

    initial begin
        if (TOTAL_W != TOTAL_W_L) $display("csr_bank: field widths must sum to %0d", TOTAL_W_L);
        if (MAP_END > (1 << ADDR_W)) $display("csr_bank: address map exceeds ADDR_W");
    end

    // ---------------- pass-through registers ----------------
    for (genvar r = 0; r < N_RAW; r++) begin : g_raw
        csr_raw_port #(
            .BUS_W  (BUS_W),
            .ADDR_W (ADDR_W),
            .MY_ADDR(r)
        ) u_raw (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .bus_addr_i (bus_addr_i),
            .bus_we_i   (bus_we_i),
            .bus_wdata_i(bus_wdata_i),
            .stb_o      (raw_wstb_o[r]),
            .data_o     (raw_wdata_o[r*BUS_W +: BUS_W])
        );
    end

    // ---------------- word decode onto the field vector ----------------
    logic [PAD_W-1:0] bus_bwe;
    logic [PAD_W-1:0] bus_bwd;

    always_comb begin
        for (int k = 0; k < N_WORDS; k++) begin
            bus_bwe[(N_WORDS-1-k)*BUS_W +: BUS_W] =
                {BUS_W{bus_we_i && (int'(bus_addr_i) == N_RAW + k)}};
        end
        bus_bwd = {N_WORDS{bus_wdata_i}};
    end

    // ---------------- fields ----------------
    logic [PAD_W-1:0] fld_val;
    logic [PAD_W-1:0] fld_view;

    for (genvar f = 0; f < N_FLD; f++) begin : g_fld
        localparam int LSB = fld_lsb(f);
        localparam int FW  = FLD_W[f];

        csr_field_store #(
            .W      (FW),
            .BUS_ACC(BUS_ACC[f]),
            .DEV_ACC(DEV_ACC[f])
        ) u_fld (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .bus_bwe_i(bus_bwe[LSB +: FW]),
            .bus_bwd_i(bus_bwd[LSB +: FW]),
            .dev_we_i (fld_we_i[f]),
            .dev_wd_i (fld_wdata_i[LSB +: FW]),
            .val_o    (fld_val[LSB +: FW]),
            .dev_rd_o (fld_rd_o[LSB +: FW]),
            .bus_rd_o (fld_view[LSB +: FW])
        );
    end

    // ---------------- registered read path ----------------
    csr_read_mux #(
        .BUS_W  (BUS_W),
        .ADDR_W (ADDR_W),
        .N_RAW  (N_RAW),
        .N_WORDS(N_WORDS)
    ) u_rd (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bus_addr_i (bus_addr_i),
        .raw_rdata_i(raw_rdata_i),
        .fld_view_i (fld_view),
        .rdata_o    (bus_rdata_o)
    );

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
    import csr_bank_pkg::*;
#(
    parameter int   BUS_W   = 8,
    parameter int   ADDR_W  = 4,
    parameter int   N_RAW   = 2,
    parameter int   N_FLD   = 4,
    parameter int   PAD_W   = 16,
    parameter int   FLD_W   [N_FLD] = '{4, 6, 3, 3},
    parameter acc_e BUS_ACC [N_FLD] = '{ACC_RW, ACC_RO, ACC_RW, ACC_WO},
    parameter acc_e DEV_ACC [N_FLD] = '{ACC_RO, ACC_WO, ACC_RW, ACC_RO}
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [BUS_W-1:0]       bus_wdata,
    input logic [BUS_W-1:0]       bus_rdata,
    input logic [N_RAW*BUS_W-1:0] raw_data,
    input logic [N_RAW-1:0]       raw_stb,
    input logic [N_RAW*BUS_W-1:0] raw_rdata,
    input logic [N_FLD-1:0]       fld_we,
    input logic [PAD_W-1:0]       fld_wdata,
    input logic [PAD_W-1:0]       fld_val
);

    function automatic int fld_lsb(int idx);
        int s = 0;
        for (int i = 0; i < idx; i++) begin
            s += FLD_W[i];
        end
        return s;
    endfunction

    localparam int MAP_END = N_RAW + PAD_W / BUS_W;

    p_stb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(raw_stb));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= MAP_END) |=> (bus_rdata == '0));

    for (genvar i = 0; i < N_RAW; i++) begin : g_raw_chk
        p_raw_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && int'(bus_addr) == i) |=> raw_stb[i]);
        p_raw_nostb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_we && int'(bus_addr) == i) |=> !raw_stb[i]);
        p_raw_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && int'(bus_addr) == i) |=> (raw_data[i*BUS_W +: BUS_W] == $past(bus_wdata)));
        p_raw_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(bus_addr) == i) |=> (bus_rdata == $past(raw_rdata[i*BUS_W +: BUS_W])));
    end

    for (genvar f = 0; f < N_FLD; f++) begin : g_fld_chk
        localparam int LSB = fld_lsb(f);
        localparam int FW  = FLD_W[f];
        if (acc_can_wr(DEV_ACC[f])) begin : g_dev_wr
            p_core_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                fld_we[f] |=> (fld_val[LSB +: FW] == $past(fld_wdata[LSB +: FW])));
        end else begin : g_dev_nowr
            p_core_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (fld_we[f] && !bus_we) |=> $stable(fld_val[LSB +: FW]));
        end
        if (!acc_can_wr(BUS_ACC[f])) begin : g_bus_nowr
            p_bus_ro_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !fld_we[f] |=> $stable(fld_val[LSB +: FW]));
        end
    end

endmodule

bind csr_bank csr_bank_chk #(
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .N_RAW  (N_RAW),
    .N_FLD  (N_FLD),
    .PAD_W  (PAD_W),
    .FLD_W  (FLD_W),
    .BUS_ACC(BUS_ACC),
    .DEV_ACC(DEV_ACC)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .bus_addr (bus_addr_i),
    .bus_we   (bus_we_i),
    .bus_wdata(bus_wdata_i),
    .bus_rdata(bus_rdata_o),
    .raw_data (raw_wdata_o),
    .raw_stb  (raw_wstb_o),
    .raw_rdata(raw_rdata_i),
    .fld_we   (fld_we_i),
    .fld_wdata(fld_wdata_i),
    .fld_val  (fld_val)
);

// File: tb/tb_csr_bank.sv
`timescale 1ns/1ps
module tb_csr_bank;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic [15:0] raw_wdata_o;
    logic [1:0]  raw_wstb_o;
    logic [15:0] raw_rdata_i = 16'h3C5A;
    logic [15:0] fld_rd_o;
    logic [3:0]  fld_we_i = '0;
    logic [15:0] fld_wdata_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk_i = ~clk_i;

    csr_bank dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bus_addr_i (bus_addr_i),
        .bus_we_i   (bus_we_i),
        .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o),
        .raw_wdata_o(raw_wdata_o),
        .raw_wstb_o (raw_wstb_o),
        .raw_rdata_i(raw_rdata_i),
        .fld_rd_o   (fld_rd_o),
        .fld_we_i   (fld_we_i),
        .fld_wdata_i(fld_wdata_i)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk_i);
        bus_addr_i = a; bus_we_i = 1'b1; bus_wdata_i = d;
        @(negedge clk_i);
        bus_we_i = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk_i);
        bus_addr_i = a;
        @(negedge clk_i);
        d = bus_rdata_o;
    endtask

    task automatic core_wr(logic [3:0] mask, logic [15:0] d);
        @(negedge clk_i);
        fld_we_i = mask; fld_wdata_i = d;
        @(negedge clk_i);
        fld_we_i = '0;
    endtask

    task automatic t_reset;
        @(negedge clk_i);
        check("R1 fields", fld_rd_o, 16'h0000);
        check("R1 strobes", raw_wstb_o, 2'b00);
        check("R1 rdata", bus_rdata_o, 8'h00);
    endtask

    task automatic t_raw_write;
        bus_wr(4'd0, 8'hA5);
        check("R2 strobe", raw_wstb_o, 2'b01);
        check("R2 data", raw_wdata_o[7:0], 8'hA5);
        @(negedge clk_i);
        check("R2 strobe one cycle", raw_wstb_o, 2'b00);
        bus_wr(4'd1, 8'h6E);
        check("R2 strobe reg1", raw_wstb_o, 2'b10);
        check("R2 data reg1", raw_wdata_o[15:8], 8'h6E);
    endtask

    task automatic t_raw_read;
        logic [7:0] d;
        bus_rd(4'd0, d);
        check("R3 read raw0", d, 8'h5A);
        bus_rd(4'd1, d);
        check("R3 read raw1", d, 8'h3C);
    endtask

    task automatic t_bus_fields;
        logic [7:0] d;
        bus_wr(4'd3, 8'hF7);
        check("R5 f0 written", fld_rd_o, 16'h0007);
        bus_rd(4'd3, d);
        check("R6 f1 unchanged by bus", d, 8'h07);
    endtask

    task automatic t_core_fields;
        logic [7:0] d;
        core_wr(4'b0010, 16'h02D0);
        check("R12 f1 hidden from core", fld_rd_o, 16'h0007);
        bus_rd(4'd3, d);
        check("R8 R4 low slice", d, 8'hD7);
        bus_rd(4'd2, d);
        check("R4 high slice", d, 8'h02);
        bus_wr(4'd2, 8'hFF);
        check("R5 f2 f3 written", fld_rd_o, 16'hFC07);
        bus_rd(4'd2, d);
        check("R7 f3 reads zero", d, 8'h1E);
        core_wr(4'b0001, 16'h0002);
        check("R8 f0 core write ignored", fld_rd_o, 16'hFC07);
    endtask

    task automatic t_collision;
        @(negedge clk_i);
        bus_addr_i = 4'd2; bus_we_i = 1'b1; bus_wdata_i = 8'h04;
        fld_we_i = 4'b0100; fld_wdata_i = 16'h1800;
        @(negedge clk_i);
        bus_we_i = 1'b0; fld_we_i = '0;
        check("R9 core wins f2", fld_rd_o, 16'h1807);
    endtask

    task automatic t_read_during_write;
        @(negedge clk_i);
        bus_addr_i = 4'd3; bus_we_i = 1'b1; bus_wdata_i = 8'h03;
        @(negedge clk_i);
        bus_we_i = 1'b0;
        check("R10 old value", bus_rdata_o, 8'hD7);
        @(negedge clk_i);
        check("R10 new value", bus_rdata_o, 8'hD3);
        check("R5 f0 rewritten", fld_rd_o, 16'h1803);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        bus_wr(4'd5, 8'hFF);
        check("R11 no strobe", raw_wstb_o, 2'b00);
        check("R11 fields kept", fld_rd_o, 16'h1803);
        bus_rd(4'd5, d);
        check("R11 reads zero", d, 8'h00);
        bus_rd(4'd2, d);
        check("R11 R4 word2 kept", d, 8'h1A);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_raw_write();
        t_raw_read();
        t_bus_fields();
        t_core_fields();
        t_collision();
        t_read_during_write();
        t_unmapped();
        repeat (2) @(negedge clk_i);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule